// File: doc/BRIEF.md
# Sensor Frame Capture Trigger Sequencer

This block sequences the capture of a single image frame from a sensor. Software arms it by writing a nonzero command word. The block then waits for the next rising edge of frame sync. In triggered mode it next waits for a trigger, which is either an external trigger edge or a virtual trigger taken from a line counter. It then counts a programmed number of scan lines and declares the frame over. All sensor-side inputs are brought into the pixel clock domain through synchronisers before they are used.

Software observes progress through a 3-bit status field. The low two bits give the current phase. The top bit is a sticky "frame done" flag, which is also driven out as a level interrupt. Two more interrupt outputs pulse on every frame sync edge and every external trigger edge, whatever the phase. A third pulse output marks the end of acquisition. The synchronised trigger level can also be read back directly.

Top module: `frame_trig_ctrl`

## Requirements
- R1: After reset, status is 3'b000, every interrupt output is 0 and trig_level is 0.
- R2: Register select codes are: 0 command, 1 line count, 2 virtual trigger threshold; code 3 is ignored. A nonzero command write clears the done bit and sets the phase to 01 (waiting for frame sync). Command bit 1 set selects triggered mode; bit 1 clear selects free-run mode.
- R3: A command write of zero aborts any capture, clears the done bit and returns the phase to 00. Later line strobes leave it at 00.
- R4: In phase 01, a rising edge on fsync_in moves the phase to 10. In free-run mode line counting starts at once; in triggered mode the block waits for a trigger.
- R5: In triggered mode, a rising edge on trig_in starts line counting. Line strobes seen before the trigger are not counted.
- R6: The virtual trigger fires on the line strobe that brings the count of lines since the last frame sync edge equal to a nonzero threshold. That strobe is not counted as a transferred line. A threshold of zero never fires.
- R7: Once the programmed number of lines has been counted after the start point, the status becomes 3'b111 and irq_over pulses for exactly one cycle. A line count of zero ends the frame right at the start point.
- R8: The done bit and irq_done stay at 1 until the next command write. Writes to the line count or threshold registers do not clear them.
- R9: irq_fsync pulses once per fsync_in rising edge and irq_trig pulses once per trig_in rising edge, in any phase, including idle.
- R10: trig_level follows the synchronised level of trig_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 command, 1 line count, 2 threshold) |
| wr_data | input | 32 | Register write data |
| fsync_in | input | 1 | Asynchronous frame sync level |
| line_in | input | 1 | Asynchronous line strobe level |
| trig_in | input | 1 | Asynchronous external trigger level |
| status | output | 3 | {done, phase[1:0]} |
| trig_level | output | 1 | Synchronised trigger level |
| irq_fsync | output | 1 | Pulse per frame sync edge |
| irq_trig | output | 1 | Pulse per external trigger edge |
| irq_over | output | 1 | Pulse when acquisition completes |
| irq_done | output | 1 | Level copy of the sticky done bit |

## Verification
The assertions assume that every sensor-side input holds each level for at least one clock, so that the synchroniser sees every edge. They also assume that register writes last a single cycle and that the line count and threshold are stable while a frame is being captured. The bench drives every sensor input high for three cycles and low for four. It issues each write for exactly one clock, and it reprograms the line count and threshold only before the arming command, or once a frame is done when the test is about stickiness.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  // State encoding: the low two bits are the reported phase.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_WSYNC = 3'b001,
    ST_WTRIG = 3'b010,
    ST_XFER  = 3'b110,
    ST_OVER  = 3'b011
  } ftc_state_e;

  localparam logic [1:0] SEL_CMD   = 2'd0;
  localparam logic [1:0] SEL_LINES = 2'd1;
  localparam logic [1:0] SEL_VTHR  = 2'd2;
  localparam int         CMD_TRIG_BIT = 1;
endpackage

// File: rtl/ftc_insync.sv
module ftc_insync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  localparam int SH_W = STAGES + 1;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic [SH_W-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SH_W-2:0], raw[i]};
    end
    assign level[i] = sh[STAGES-1];
    assign rise[i]  = sh[STAGES-1] & ~sh[STAGES];

    // R9: an edge detector cannot produce two pulses in a row
    a_r9_rise_single: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]);
  end
endmodule

// File: rtl/ftc_regfile.sv
module ftc_regfile
  import ftc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmd_wr,
  output logic              cmd_zero,
  output logic              cmd_trig,
  output logic [LINE_W-1:0] lines_q,
  output logic [LINE_W-1:0] thr_q
);
  assign cmd_wr   = wr_en && (wr_sel == SEL_CMD);
  assign cmd_zero = (wr_data == '0);
  assign cmd_trig = wr_data[CMD_TRIG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      lines_q <= '0;
      thr_q   <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_LINES) lines_q <= wr_data[LINE_W-1:0];
      if (wr_sel == SEL_VTHR)  thr_q   <= wr_data[LINE_W-1:0];
    end
  end

  // R2: registers change only on their own select code
  a_r2_lines_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == SEL_LINES) |=> $stable(lines_q));
  a_r2_thr_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_sel == SEL_VTHR) |=> $stable(thr_q));
endmodule

// File: rtl/ftc_sequencer.sv
module ftc_sequencer
  import ftc_pkg::*;
#(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic              cmd_zero,
  input  logic              cmd_trig,
  input  logic [LINE_W-1:0] lines_q,
  input  logic [LINE_W-1:0] thr_q,
  input  logic              fs_p,
  input  logic              ln_p,
  input  logic              tr_p,
  output logic [2:0]        status,
  output logic              irq_fsync,
  output logic              irq_trig,
  output logic              irq_over
);
  ftc_state_e        state;
  logic              done;
  logic              trig_mode;
  logic [LINE_W-1:0] xcnt;
  logic [LINE_W-1:0] vcnt;
  logic              vtrig;

  // Virtual trigger: line count since the last frame sync reaches the threshold
  assign vtrig = ln_p && !fs_p && (thr_q != '0) && ((vcnt + 1'b1) == thr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b0;
      trig_mode <= 1'b0;
      xcnt      <= '0;
      vcnt      <= '0;
      irq_fsync <= 1'b0;
      irq_trig  <= 1'b0;
      irq_over  <= 1'b0;
    end else begin
      irq_fsync <= fs_p;
      irq_trig  <= tr_p;
      irq_over  <= 1'b0;

      if (fs_p)      vcnt <= '0;
      else if (ln_p) vcnt <= vcnt + 1'b1;

      if (cmd_wr) begin
        done      <= 1'b0;
        xcnt      <= '0;
        trig_mode <= cmd_trig;
        state     <= cmd_zero ? ST_IDLE : ST_WSYNC;
      end else begin
        case (state)
          ST_WSYNC: if (fs_p) begin
            xcnt  <= '0;
            state <= trig_mode ? ST_WTRIG : ST_XFER;
          end
          ST_WTRIG: if (tr_p || vtrig) begin
            xcnt  <= '0;
            state <= ST_XFER;
          end
          ST_XFER: begin
            if (lines_q == '0) begin
              state    <= ST_OVER;
              done     <= 1'b1;
              irq_over <= 1'b1;
            end else if (ln_p) begin
              if ((xcnt + 1'b1) == lines_q) begin
                state    <= ST_OVER;
                done     <= 1'b1;
                irq_over <= 1'b1;
              end else begin
                xcnt <= xcnt + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign status = {done, state[1:0]};

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !cmd_wr) |=> state == ST_IDLE);
  a_r2_start: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && !cmd_zero) |=> (state == ST_WSYNC && !done));
  a_r3_abort: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && cmd_zero) |=> (state == ST_IDLE && !done));
  a_r4_wait_sync: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WSYNC && !fs_p && !cmd_wr) |=> state == ST_WSYNC);
  a_r5_wait_trig: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WTRIG && !tr_p && !ln_p && !cmd_wr) |=> state == ST_WTRIG);
  a_r7_over_single: assert property (@(posedge clk) disable iff (rst)
    irq_over |=> !irq_over);
  a_r7_over_done: assert property (@(posedge clk) disable iff (rst)
    irq_over |-> (done && state == ST_OVER));
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (done && !cmd_wr) |=> done);
endmodule

// File: rtl/frame_trig_ctrl.sv
module frame_trig_ctrl
  import ftc_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int LINE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fsync_in,
  input  logic              line_in,
  input  logic              trig_in,
  output logic [2:0]        status,
  output logic              trig_level,
  output logic              irq_fsync,
  output logic              irq_trig,
  output logic              irq_over,
  output logic              irq_done
);
  localparam int N_IN = 3;

  logic [N_IN-1:0]   lvl, rise;
  logic              cmd_wr, cmd_zero, cmd_trig;
  logic [LINE_W-1:0] lines_q, thr_q;
  logic [N_IN-1:0]   unused_lvl;

  ftc_insync #(.N(N_IN), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst   (rst),
    .raw   ({trig_in, line_in, fsync_in}),
    .level (lvl),
    .rise  (rise)
  );

  ftc_regfile #(.DATA_W(DATA_W), .LINE_W(LINE_W)) regs_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cmd_wr   (cmd_wr),
    .cmd_zero (cmd_zero),
    .cmd_trig (cmd_trig),
    .lines_q  (lines_q),
    .thr_q    (thr_q)
  );

  ftc_sequencer #(.LINE_W(LINE_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_zero  (cmd_zero),
    .cmd_trig  (cmd_trig),
    .lines_q   (lines_q),
    .thr_q     (thr_q),
    .fs_p      (rise[0]),
    .ln_p      (rise[1]),
    .tr_p      (rise[2]),
    .status    (status),
    .irq_fsync (irq_fsync),
    .irq_trig  (irq_trig),
    .irq_over  (irq_over)
  );

  assign trig_level = lvl[2];
  assign unused_lvl = {1'b0, lvl[1:0]};
  assign irq_done   = status[2];

  // R8: the done interrupt drops only after a command write
  a_r8_irq_done_level: assert property (@(posedge clk) disable iff (rst)
    (irq_done && !(wr_en && wr_sel == SEL_CMD)) |=> irq_done);
  // R3: an abort leaves no pending done level
  a_r3_abort_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == SEL_CMD && wr_data == '0) |=> (status == 3'b000));
endmodule

// File: tb/frame_trig_ctrl_tb.sv
module frame_trig_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        fsync_in = 1'b0, line_in = 1'b0, trig_in = 1'b0;
  logic [2:0]  status;
  logic        trig_level, irq_fsync, irq_trig, irq_over, irq_done;

  int checks = 0;
  int errors = 0;
  int n_fs = 0, n_tr = 0, n_ov = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_trig_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .fsync_in(fsync_in), .line_in(line_in), .trig_in(trig_in),
    .status(status), .trig_level(trig_level), .irq_fsync(irq_fsync),
    .irq_trig(irq_trig), .irq_over(irq_over), .irq_done(irq_done)
  );

  always @(posedge clk) begin
    if (irq_fsync) n_fs <= n_fs + 1;
    if (irq_trig)  n_tr <= n_tr + 1;
    if (irq_over)  n_ov <= n_ov + 1;
  end

  typedef struct packed {
    logic       trig;
    logic       ext;
    logic [7:0] thr;
    logic [7:0] lines;
    logic [7:0] pre;
    logic [7:0] post;
    logic [2:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd0, 8'd3, 8'd0, 8'd3, 3'b111}, // R4/R7 free run, exact count
    '{1'b0, 1'b0, 8'd0, 8'd4, 8'd0, 8'd2, 3'b010}, // R7 short of count
    '{1'b1, 1'b1, 8'd0, 8'd2, 8'd3, 8'd2, 3'b111}, // R5 pre-trigger lines ignored
    '{1'b1, 1'b1, 8'd0, 8'd3, 8'd2, 8'd1, 3'b010}, // R5 too few after trigger
    '{1'b1, 1'b0, 8'd2, 8'd2, 8'd2, 8'd2, 3'b111}, // R6 virtual trigger
    '{1'b1, 1'b0, 8'd0, 8'd1, 8'd2, 8'd2, 3'b010}, // R6 zero threshold never fires
    '{1'b1, 1'b0, 8'd5, 8'd2, 8'd2, 8'd2, 3'b010}, // R6 threshold not reached
    '{1'b0, 1'b0, 8'd0, 8'd0, 8'd0, 8'd0, 3'b111}, // R7 zero lines free run
    '{1'b1, 1'b0, 8'd1, 8'd3, 8'd1, 8'd3, 3'b111}, // R6 threshold of one
    '{1'b1, 1'b1, 8'd0, 8'd0, 8'd1, 8'd0, 3'b111}  // R7 zero lines after trigger
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse_fs();
    fsync_in = 1'b1; tick(3); fsync_in = 1'b0; tick(4);
  endtask
  task automatic pulse_ln();
    line_in = 1'b1; tick(3); line_in = 1'b0; tick(4);
  endtask
  task automatic pulse_tr();
    trig_in = 1'b1; tick(3); trig_in = 1'b0; tick(4);
  endtask

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    check("R1 status", status, 0);
    check("R1 irqs", {irq_fsync, irq_trig, irq_over, irq_done}, 0);
    check("R1 trig_level", trig_level, 0);

    for (int i = 0; i < NV; i++) begin
      int fs0, tr0, ov0;
      vec_t v;
      v = VECS[i];
      wr(2'd1, {24'd0, v.lines});
      wr(2'd2, {24'd0, v.thr});
      wr(2'd0, v.trig ? 32'd2 : 32'd1);
      check("R2 armed", status, 3'b001);
      fs0 = n_fs; tr0 = n_tr; ov0 = n_ov;
      pulse_fs();
      check("R4 after sync", status, (!v.trig && v.lines == 0) ? 3'b111 : 3'b010);
      for (int k = 0; k < int'(v.pre); k++) pulse_ln();
      if (v.ext) pulse_tr();
      for (int k = 0; k < int'(v.post); k++) pulse_ln();
      check(v.ext ? "R5 final" : (v.trig ? "R6 final" : "R7 final"), status, v.exp);
      check("R7 over pulses", n_ov - ov0, v.exp[2] ? 1 : 0);
      check("R9 fsync pulses", n_fs - fs0, 1);
      check("R9 trig pulses", n_tr - tr0, v.ext ? 1 : 0);
      if (v.exp[2]) begin
        wr(2'd1, 32'd99);
        wr(2'd2, 32'd7);
        wr(2'd3, 32'd5);
        check("R8 sticky status", status, 3'b111);
        check("R8 irq_done", irq_done, 1);
      end
    end

    // R3 abort while waiting for trigger
    wr(2'd1, 32'd2);
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd2);
    pulse_fs();
    check("R3 pre-abort", status, 3'b010);
    wr(2'd0, 32'd0);
    check("R3 abort idle", status, 3'b000);
    pulse_ln(); pulse_ln(); pulse_ln();
    check("R3 stays idle", status, 3'b000);

    // R3/R8 abort from done
    wr(2'd1, 32'd0);
    wr(2'd0, 32'd1);
    pulse_fs();
    check("R8 done set", status, 3'b111);
    wr(2'd0, 32'd0);
    check("R3 done cleared", status, 3'b000);
    check("R8 irq_done cleared", irq_done, 0);

    // R9 interrupts in idle
    begin
      int fs0, tr0;
      fs0 = n_fs; tr0 = n_tr;
      pulse_fs();
      pulse_tr();
      check("R9 idle fsync", n_fs - fs0, 1);
      check("R9 idle trig", n_tr - tr0, 1);
      check("R9 idle status", status, 3'b000);
    end

    // R10 trigger level readback
    trig_in = 1'b1; tick(4);
    check("R10 level high", trig_level, 1);
    trig_in = 1'b0; tick(4);
    check("R10 level low", trig_level, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule